// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps the time of day and the calendar as packed BCD fields: seconds, minutes, hours, day of week, date, month and year, plus a century flag. A one-cycle pulse on `tick` marks each elapsed second. On each pulse the seconds field advances and carries ripple through minutes, hours, day, date, month and year. Date rollover follows the length of the current month, with February taking 29 days in leap years.

A byte-wide register port with a 4-bit register index gives access to the fields. Reads are combinational and show the live time. Writes to time fields are masked to the field's width. A write is kept only when every nibble is a decimal digit and the value lies in the field's legal range. Otherwise the field holds its old value.

A two-state run controller owns the clock-stop bit, which is bit 7 of the seconds register. State `ST_RUN` moves to `ST_HALT` on transition HALT_SET, a seconds write with bit 7 at 1. State `ST_HALT` moves back to `ST_RUN` on transition RESUME, a seconds write with bit 7 at 0. In `ST_HALT`, ticks are discarded, so counting later picks up from the frozen value. A control byte with forced bits completes the map. The parameter `BASE_YEAR` sets the calendar year that a stored year of 00 stands for, and leap years are judged from that year plus the stored year.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset every register reads its minimum: control 0x00, seconds 0x00 with the stop bit clear, minutes 0x00, hours 0x00, day 0x00, date 0x01, month 0x01, year 0x00.
- R2: The register index map is 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A tick while running advances seconds in BCD. Seconds 59 wraps to 00 and carries into minutes; minutes 59 carries into hours; hours 23 wraps to 00 and advances the day of week (0 to 6, and any value of 6 or more goes to 0) and the date.
- R3: When the date carry arrives, a date at or beyond the month's last day (28, 29 in a leap year, 30 for months 4, 6, 9 and 11, otherwise 31) goes to 01 and advances the month. Month 12 goes to 01 and advances the year. Year 99 goes to 00 and toggles the century flag. A year is a leap year when (BASE_YEAR + year) mod 4 is 0.
- R4: A write to seconds or minutes uses bits 6:0 as BCD and is kept only for a value from 00 to 59 with both nibbles decimal.
- R5: A write to hours uses bits 5:0 as BCD and is kept only for a value from 00 to 23 with a decimal low nibble.
- R6: A write to date uses bits 5:0 and is kept only for 01 to 31. A write to month uses bits 4:0 and is kept only for 01 to 12. Both nibbles must be decimal.
- R7: A write to year uses all 8 bits as BCD and is kept only for 00 to 99 with both nibbles decimal.
- R8: Bit 7 of every seconds write sets the stop bit, whether or not the field value is kept. While the stop bit is set, ticks change nothing. A seconds read returns the stop bit in bit 7 above the BCD seconds. After the stop bit is cleared, counting resumes from the frozen time.
- R9: A day write keeps bit 6 as the century flag and bits 2:0 as the day of week. A day read returns only those bits, with every other bit at 0.
- R10: A control write stores the written byte with bits 7 and 5 cleared and then bits 7 and 4 set.
- R11: Register indices 8 to 15 read as 0x00, and writes to them change no register.
- R12: When `wr_en` is high in the same cycle as `tick`, the write is applied and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data of the indexed register |

## Verification
Directed sequences place the clock one tick before each carry boundary. The boundaries are the end of a minute, the end of a day, February 28 in a common year and in a leap year, the end of a 30-day month, and the end of a century. Together they separate a wrong month-length table, a wrong leap rule and a missing century toggle. Write patterns with bad nibbles, out-of-range values and set upper bits show whether masking happens before the range check. The stop sequence resumes through a rejected seconds value, which shows that the stop bit and the field are updated independently. A long run of seeded random ticks and writes, compared against a decimal model after every few dozen steps, catches carry and write-priority errors that the directed cases do not reach.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_t;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_SEC  = 3'd1,
        RG_MIN  = 3'd2,
        RG_HOUR = 3'd3,
        RG_DAY  = 3'd4,
        RG_DATE = 3'd5,
        RG_MON  = 3'd6,
        RG_YEAR = 3'd7
    } reg_sel_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] yr;
        logic [2:0] dow;
        logic       cent;
    } tod_t;

    // Next BCD value; caller guarantees the input is a legal BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Both nibbles decimal and value within [lo, hi] (BCD order equals numeric order).
    function automatic logic bcd_in_range(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_run_fsm.sv
module rtc_run_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_wr,
    input  logic halt_req,
    output logic running,
    output logic halted
);

    run_state_t state_q;
    run_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (sec_wr && halt_req)  state_d = ST_HALT;  // HALT_SET
            ST_HALT: if (sec_wr && !halt_req) state_d = ST_RUN;   // RESUME
        endcase
    end

    always_comb begin
        running = (state_q == ST_RUN);
        halted  = (state_q == ST_HALT);
    end

endmodule

// File: rtl/rtc_tod_core.sv
module rtc_tod_core
    import rtc_pkg::*;
#(
    parameter int BASE_YEAR = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_go,
    input  logic       wr_hit,
    input  reg_sel_t   wsel,
    input  logic [7:0] wdata,
    output tod_t       tod,
    output logic [7:0] ctrl
);

    localparam logic [1:0] LEAP_PHASE = 2'(BASE_YEAR % 4);
    localparam tod_t       TOD_RESET  = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                          date: 8'h01, mon: 8'h01, yr: 8'h00,
                                          dow: 3'd0, cent: 1'b0};

    tod_t       tod_q, tod_d;
    logic [7:0] ctrl_q, ctrl_d;
    logic [6:0] yr_bin;
    logic       leap;
    logic [7:0] last_day;

    always_comb begin
        yr_bin   = 7'(tod_q.yr[7:4]) * 7'd10 + 7'(tod_q.yr[3:0]);
        leap     = ((yr_bin[1:0] + LEAP_PHASE) == 2'b00);
        last_day = month_last(tod_q.mon, leap);
    end

    always_comb begin
        tod_d  = tod_q;
        ctrl_d = ctrl_q;
        if (tick_go) begin
            if (tod_q.sec != 8'h59) tod_d.sec = bcd_inc(tod_q.sec);
            else begin
                tod_d.sec = 8'h00;
                if (tod_q.min != 8'h59) tod_d.min = bcd_inc(tod_q.min);
                else begin
                    tod_d.min = 8'h00;
                    if (tod_q.hr != 8'h23) tod_d.hr = bcd_inc(tod_q.hr);
                    else begin
                        tod_d.hr  = 8'h00;
                        tod_d.dow = (tod_q.dow >= 3'd6) ? 3'd0 : tod_q.dow + 3'd1;
                        if (tod_q.date < last_day) tod_d.date = bcd_inc(tod_q.date);
                        else begin
                            tod_d.date = 8'h01;
                            if (tod_q.mon != 8'h12) tod_d.mon = bcd_inc(tod_q.mon);
                            else begin
                                tod_d.mon = 8'h01;
                                if (tod_q.yr != 8'h99) tod_d.yr = bcd_inc(tod_q.yr);
                                else begin
                                    tod_d.yr   = 8'h00;
                                    tod_d.cent = ~tod_q.cent;
                                end
                            end
                        end
                    end
                end
            end
        end
        if (wr_hit) begin
            unique case (wsel)
                RG_CTRL: ctrl_d = (wdata & 8'h5F) | 8'h90;
                RG_SEC:  if (bcd_in_range({1'b0, wdata[6:0]}, 8'h00, 8'h59))
                             tod_d.sec = {1'b0, wdata[6:0]};
                RG_MIN:  if (bcd_in_range({1'b0, wdata[6:0]}, 8'h00, 8'h59))
                             tod_d.min = {1'b0, wdata[6:0]};
                RG_HOUR: if (bcd_in_range({2'b00, wdata[5:0]}, 8'h00, 8'h23))
                             tod_d.hr = {2'b00, wdata[5:0]};
                RG_DAY:  begin
                             tod_d.cent = wdata[6];
                             tod_d.dow  = wdata[2:0];
                         end
                RG_DATE: if (bcd_in_range({2'b00, wdata[5:0]}, 8'h01, 8'h31))
                             tod_d.date = {2'b00, wdata[5:0]};
                RG_MON:  if (bcd_in_range({3'b000, wdata[4:0]}, 8'h01, 8'h12))
                             tod_d.mon = {3'b000, wdata[4:0]};
                RG_YEAR: if (bcd_in_range(wdata, 8'h00, 8'h99))
                             tod_d.yr = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q  <= TOD_RESET;
            ctrl_q <= 8'h00;
        end else begin
            tod_q  <= tod_d;
            ctrl_q <= ctrl_d;
        end
    end

    assign tod  = tod_q;
    assign ctrl = ctrl_q;

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  tod_t              tod,
    input  logic [7:0]        ctrl,
    input  logic              halted,
    output logic [7:0]        rdata
);

    always_comb begin
        rdata = 8'h00;
        if (addr[ADDR_W-1:3] == '0) begin
            unique case (reg_sel_t'(addr[2:0]))
                RG_CTRL: rdata = ctrl;
                RG_SEC:  rdata = {halted, tod.sec[6:0]};
                RG_MIN:  rdata = tod.min;
                RG_HOUR: rdata = tod.hr;
                RG_DAY:  rdata = {1'b0, tod.cent, 3'b000, tod.dow};
                RG_DATE: rdata = tod.date;
                RG_MON:  rdata = tod.mon;
                RG_YEAR: rdata = tod.yr;
            endcase
        end
    end

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int BASE_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic     in_map;
    logic     wr_hit;
    logic     sec_wr;
    logic     tick_go;
    logic     running;
    logic     halted;
    reg_sel_t wsel;
    tod_t     tod_q;
    logic [7:0] ctrl_q;

    always_comb begin
        in_map  = (addr[ADDR_W-1:3] == '0);
        wsel    = reg_sel_t'(addr[2:0]);
        wr_hit  = wr_en && in_map;
        sec_wr  = wr_hit && (wsel == RG_SEC);
        tick_go = tick && running && !wr_en;
    end

    rtc_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_wr   (sec_wr),
        .halt_req (wdata[7]),
        .running  (running),
        .halted   (halted)
    );

    rtc_tod_core #(.BASE_YEAR(BASE_YEAR)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_go (tick_go),
        .wr_hit  (wr_hit),
        .wsel    (wsel),
        .wdata   (wdata),
        .tod     (tod_q),
        .ctrl    (ctrl_q)
    );

    rtc_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .addr   (addr),
        .tod    (tod_q),
        .ctrl   (ctrl_q),
        .halted (halted),
        .rdata  (rdata)
    );

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              running,
    input tod_t              tod,
    input logic [7:0]        ctrl
);

    AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tod.sec[3:0] <= 4'd9) && (tod.sec <= 8'h59));  // R2

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !wr_en && tod.sec[3:0] != 4'h9)
        |=> (tod.sec == $past(tod.sec) + 8'd1));  // R2

    AST_CAL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tod.date >= 8'h01) && (tod.date <= 8'h31) && (tod.mon >= 8'h01) && (tod.mon <= 8'h12));  // R3

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(tod));  // R8

    AST_CTRL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> ((ctrl & 8'hB0) == 8'h90));  // R10

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:3] != '0) |-> (rdata == 8'h00));  // R11

endmodule

bind bcd_rtc_regs rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .running (running),
    .tod     (tod_q),
    .ctrl    (ctrl_q)
);

// File: tb/bcd_rtc_regs_tb.sv
module bcd_rtc_regs_tb;

    localparam int BASE_YEAR = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // decimal reference model
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
    bit m_cent, m_halt;
    logic [7:0] m_ctrl;

    always #10 clk = ~clk;

    bcd_rtc_regs #(.ADDR_W(4), .BASE_YEAR(BASE_YEAR)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic bit digits_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    function automatic int from_bcd(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int month_days(input int m, input int y);
        if (m == 2) return ((BASE_YEAR + y) % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic void model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_dow = 0; m_date = 1; m_mon = 1; m_yr = 0;
        m_cent = 0; m_halt = 0; m_ctrl = 8'h00;
    endfunction

    function automatic void model_tick();
        if (m_halt) return;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_dow = (m_dow >= 6) ? 0 : m_dow + 1;
        if (m_date < month_days(m_mon, m_yr)) begin m_date++; return; end
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_yr++;
        if (m_yr <= 99) return;
        m_yr = 0; m_cent = ~m_cent;
    endfunction

    function automatic void model_write(input int a, input logic [7:0] v);
        logic [7:0] f;
        int d;
        case (a)
            0: m_ctrl = (v & 8'h5F) | 8'h90;
            1: begin m_halt = v[7]; f = {1'b0, v[6:0]}; d = from_bcd(f);
                     if (digits_ok(f) && d <= 59) m_sec = d; end
            2: begin f = {1'b0, v[6:0]}; d = from_bcd(f);
                     if (digits_ok(f) && d <= 59) m_min = d; end
            3: begin f = {2'b00, v[5:0]}; d = from_bcd(f);
                     if (digits_ok(f) && d <= 23) m_hr = d; end
            4: begin m_cent = v[6]; m_dow = int'(v[2:0]); end
            5: begin f = {2'b00, v[5:0]}; d = from_bcd(f);
                     if (digits_ok(f) && d >= 1 && d <= 31) m_date = d; end
            6: begin f = {3'b000, v[4:0]}; d = from_bcd(f);
                     if (digits_ok(f) && d >= 1 && d <= 12) m_mon = d; end
            7: begin d = from_bcd(v); if (digits_ok(v)) m_yr = d; end
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] expect_reg(input int a);
        logic [7:0] s;
        case (a)
            0: return m_ctrl;
            1: begin s = to_bcd(m_sec); return {m_halt, s[6:0]}; end
            2: return to_bcd(m_min);
            3: return to_bcd(m_hr);
            4: return {1'b0, m_cent, 3'b000, 3'(m_dow)};
            5: return to_bcd(m_date);
            6: return to_bcd(m_mon);
            7: return to_bcd(m_yr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one clock with optional write and tick; model follows R12
    task automatic step(input bit wr, input int a, input logic [7:0] v, input bit tk);
        @(negedge clk);
        wr_en = wr; addr = 4'(a); wdata = v; tick = tk;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick = 1'b0;
        if (wr) model_write(a, v);
        else if (tk) model_tick();
    endtask

    task automatic wr(input int a, input logic [7:0] v);
        step(1'b1, a, v, 1'b0);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 8'h00, 1'b1);
    endtask

    task automatic chk_reg(input string tag, input int a);
        addr = 4'(a);
        #1;
        check(tag, rdata, expect_reg(a));
    endtask

    task automatic chk_all(input string tag);
        for (int a = 0; a < 10; a++) chk_reg(tag, a);
    endtask

    task automatic set_clock(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                             input logic [7:0] dy, input logic [7:0] dt,
                             input logic [7:0] mo, input logic [7:0] yr);
        wr(7, yr); wr(6, mo); wr(5, dt); wr(4, dy); wr(3, h); wr(2, mi); wr(1, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk_all("R1 reset values");

        // R2: second/minute/hour carries and day of week wrap
        set_clock(8'h23, 8'h59, 8'h58, 8'h06, 8'h10, 8'h05, 8'h21);
        tk(1); chk_reg("R2 seconds step", 1);
        tk(1); chk_all("R2 day carry with dow wrap");
        set_clock(8'h10, 8'h07, 8'h59, 8'h02, 8'h10, 8'h05, 8'h21);
        tk(1); chk_all("R2 minute carry");

        // R3: month length, leap year, year and century rollover
        set_clock(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h03);
        tk(1); chk_all("R3 common-year Feb 28 to Mar 1");
        set_clock(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h04);
        tk(1); chk_all("R3 leap-year Feb 28 to Feb 29");
        tk(86400 - 1); tk(1); chk_all("R3 leap-year Feb 29 to Mar 1");
        set_clock(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h10);
        tk(1); chk_all("R3 April 30 to May 1");
        set_clock(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
        tk(1); chk_all("R3 year 99 rollover toggles century");

        // R4: seconds / minutes write filtering
        wr(1, 8'h42); chk_reg("R4 seconds 42 kept", 1);
        wr(1, 8'h60); chk_reg("R4 seconds 60 dropped", 1);
        wr(1, 8'h1A); chk_reg("R4 seconds bad nibble dropped", 1);
        wr(2, 8'h5A); chk_reg("R4 minutes bad nibble dropped", 2);
        wr(2, 8'h73); chk_reg("R4 minutes 73 dropped", 2);

        // R5: hours
        wr(3, 8'h24); chk_reg("R5 hours 24 dropped", 3);
        wr(3, 8'hC9); chk_reg("R5 hours upper bits masked", 3);
        wr(3, 8'h23); chk_reg("R5 hours 23 kept", 3);

        // R6: date and month
        wr(5, 8'h00); chk_reg("R6 date 00 dropped", 5);
        wr(5, 8'h32); chk_reg("R6 date 32 dropped", 5);
        wr(5, 8'hF1); chk_reg("R6 date upper bits masked", 5);
        wr(6, 8'h13); chk_reg("R6 month 13 dropped", 6);
        wr(6, 8'h00); chk_reg("R6 month 00 dropped", 6);
        wr(6, 8'hE9); chk_reg("R6 month upper bits masked", 6);

        // R7: year
        wr(7, 8'h9A); chk_reg("R7 year bad nibble dropped", 7);
        wr(7, 8'hA0); chk_reg("R7 year A0 dropped", 7);
        wr(7, 8'h99); chk_reg("R7 year 99 kept", 7);

        // R8: stop bit
        wr(1, 8'hB0); chk_reg("R8 stop set with seconds 30", 1);
        tk(5); chk_all("R8 ticks ignored while stopped");
        wr(1, 8'hF7); chk_reg("R8 stop kept with rejected value", 1);
        wr(1, 8'h70); chk_reg("R8 resume keeps frozen seconds", 1);
        tk(1); chk_reg("R8 counting resumes", 1);

        // R9: day register
        wr(4, 8'hFF); chk_reg("R9 day keeps century and dow", 4);
        wr(4, 8'h3B); chk_reg("R9 day clears century", 4);

        // R10: control register
        wr(0, 8'hFF); chk_reg("R10 control ff", 0);
        wr(0, 8'h00); chk_reg("R10 control 00", 0);
        wr(0, 8'h2A); chk_reg("R10 control 2a", 0);

        // R11: unused indices
        wr(9, 8'h55); chk_reg("R11 unused index 9 reads zero", 9);
        wr(15, 8'hFF);
        addr = 4'd15; #1; check("R11 unused index 15 reads zero", rdata, 8'h00);
        chk_all("R11 unused writes leave map unchanged");

        // R12: write and tick in the same cycle
        step(1'b1, 2, 8'h11, 1'b1); chk_all("R12 tick dropped under write");
        step(1'b1, 12, 8'h00, 1'b1); chk_reg("R12 tick dropped under unused write", 1);

        // seeded random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 60) step(1'b0, 0, 8'h00, 1'b1);
            else if (r < 85) begin
                int a;
                logic [7:0] v;
                a = $urandom_range(0, 11);
                v = ($urandom_range(0, 1) == 1) ? 8'($urandom) : to_bcd($urandom_range(0, 59));
                step(1'b1, a, v, $urandom_range(0, 1) == 1);
            end else step(1'b0, 0, 8'h00, 1'b0);
            if (i % 40 == 39) chk_all("R2 R3 R12 random mix");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule